// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a translation miss. It takes a 48-bit virtual address and the frame number of the top-level table. It then reads one entry from each of four radix tables held in memory, starting at the top table and ending at the leaf. Each read uses a 9-bit slice of the virtual address as its index. Each entry it returns gives the frame of the next table. The entry read from the last table gives the physical frame.

A walk ends in one of two ways. If every entry is present, the block first pulses a TLB fill with the new page mapping. On the following cycle it reports completion with the full physical address. If any entry it reads has its present bit clear, the walk stops at that point and reports a page fault. The fault report carries the virtual address and the level where the walk stopped.

Memory is reached through a plain read request/response pair, and only one read is outstanding at a time. The block accepts a new request only while it is idle.

Top module: `page_walker`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `mem_rd_valid`, `fill_valid` and `done_valid` are all 0.
- R2: The table index used at level k (k = 0 for the top table, 3 for the leaf) is virtual address bits [47-9k : 39-9k]. Level 0 uses bits 47:39, level 1 uses 38:30, level 2 uses 29:21 and level 3 uses 20:12.
- R3: The read address for a level is {table frame, index, 3'b000}, which is the table base plus 8 times the index. The level 0 table frame is `root_pfn` as captured when the request is accepted. The table frame for each later level is bits 51:12 of the entry read at the level before it.
- R4: At most one read is in flight. `mem_rd_valid` stays high with a stable address until `mem_rd_ready` is seen. No new read is issued until `mem_rsp_valid` returns the entry for the current read.
- R5: If an entry has bit 0 (present) equal to 0, the next cycle shows `done_valid`=1 with `done_fault`=1, `done_level` set to that level, and `done_vaddr` equal to the request address. No further read and no TLB fill follow.
- R6: After a present leaf entry, `fill_valid` pulses for one cycle with `fill_vpn` = VA[47:12] and `fill_pfn` = leaf bits 51:12. On the cycle after that, `done_valid` pulses with `done_fault`=0, `done_level`=3 and `done_paddr` = {leaf frame, VA[11:0]}.
- R7: `req_ready` is 0 from acceptance until the cycle after `done_valid`. While it is 0, `req_valid` is ignored, and no extra walk starts once the current walk ends.
- R8: Entry bits 63:52 and 11:1 have no effect on addresses, frames or fault decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Idle, able to accept a walk |
| req_vaddr | input | 48 | Virtual address to translate |
| root_pfn | input | 40 | Frame number of the top-level table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |
| fill_valid | output | 1 | TLB fill pulse |
| fill_vpn | output | 36 | Virtual page number to install |
| fill_pfn | output | 40 | Physical frame to install |
| done_valid | output | 1 | Walk finished |
| done_fault | output | 1 | Walk ended on a non-present entry |
| done_level | output | 2 | Level where the walk ended |
| done_vaddr | output | 48 | Virtual address of the walk |
| done_paddr | output | 52 | Translated physical address |

## Verification
The hardest case to reach from the ports is a fault at one chosen depth after a chain of correctly followed entries. Reaching it needs a memory whose contents depend on every earlier read. The bench answers each read with an entry computed from the read address. It clears the present bit only at the selected level, so it sweeps fault depths 0 to 3 and a clean walk over several address patterns. It also varies the acceptance and response delays, and it raises `req_valid` while a walk is in progress.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 48;
  localparam int PA_W    = 52;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int LEVELS  = 4;
  localparam int ENT_W   = 64;
  localparam int ENT_LG  = 3;
  localparam int PFN_W   = PA_W - OFF_W;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int LVL_W   = $clog2(LEVELS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_FILL,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
  parameter int VA_W   = 48,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 9,
  parameter int LEVELS = 4,
  parameter int PFN_W  = 40,
  parameter int ENT_LG = 3,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int ADR_W = PFN_W + IDX_W + ENT_LG
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  input  logic [PFN_W-1:0] table_pfn,
  output logic [ADR_W-1:0] entry_addr
);
  logic [IDX_W-1:0] slice [LEVELS];

  // level 0 takes the topmost slice, the last level sits just above the offset
  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = vaddr[OFF_W + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  assign entry_addr = {table_pfn, slice[level], {ENT_LG{1'b0}}};
endmodule

// File: rtl/ptw_entry_dec.sv
module ptw_entry_dec #(
  parameter int ENT_W = 64,
  parameter int OFF_W = 12,
  parameter int PFN_W = 40
) (
  input  logic [ENT_W-1:0] entry,
  output logic             present,
  output logic [PFN_W-1:0] next_pfn
);
  assign present  = entry[0];
  assign next_pfn = entry[OFF_W +: PFN_W];
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4,
  parameter int PFN_W  = 40,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int VPN_W = VA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PFN_W-1:0] root_pfn,
  output logic             req_ready,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  input  logic             mem_rsp_valid,
  input  logic             rsp_present,
  input  logic [PFN_W-1:0] rsp_pfn,
  output logic [LVL_W-1:0] cur_level,
  output logic [PFN_W-1:0] cur_pfn,
  output logic [VA_W-1:0]  cur_vaddr,
  output logic             fill_valid,
  output logic [VPN_W-1:0] fill_vpn,
  output logic [PFN_W-1:0] fill_pfn,
  output logic             done_valid,
  output logic             done_fault,
  output logic [LVL_W-1:0] done_level,
  output logic [VA_W+PFN_W-VA_W+OFF_W-1:0] done_paddr
);
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);

  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic [PFN_W-1:0] base_q,  base_d;
  logic [VA_W-1:0]  va_q,    va_d;
  logic             fault_q, fault_d;
  logic             level_en, base_en, va_en, fault_en;

  always_comb begin
    state_d  = state_q;
    level_d  = level_q;
    base_d   = base_q;
    va_d     = va_q;
    fault_d  = fault_q;
    level_en = 1'b0;
    base_en  = 1'b0;
    va_en    = 1'b0;
    fault_en = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        state_d  = ST_REQ;
        va_d     = req_vaddr;
        base_d   = root_pfn;
        level_d  = '0;
        fault_d  = 1'b0;
        va_en    = 1'b1;
        base_en  = 1'b1;
        level_en = 1'b1;
        fault_en = 1'b1;
      end
      ST_REQ: if (mem_rd_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) begin
        if (!rsp_present) begin
          fault_d  = 1'b1;
          fault_en = 1'b1;
          state_d  = ST_DONE;
        end else begin
          base_d  = rsp_pfn;
          base_en = 1'b1;
          if (level_q == LAST_LVL) begin
            state_d = ST_FILL;
          end else begin
            level_d  = level_q + 1'b1;
            level_en = 1'b1;
            state_d  = ST_REQ;
          end
        end
      end
      ST_FILL: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      level_q <= '0;
      base_q  <= '0;
      va_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (level_en) level_q <= level_d;
      if (base_en)  base_q  <= base_d;
      if (va_en)    va_q    <= va_d;
      if (fault_en) fault_q <= fault_d;
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_REQ);
  assign fill_valid   = (state_q == ST_FILL);
  assign done_valid   = (state_q == ST_DONE);
  assign cur_level    = level_q;
  assign cur_pfn      = base_q;
  assign cur_vaddr    = va_q;
  assign fill_vpn     = va_q[VA_W-1:OFF_W];
  assign fill_pfn     = base_q;
  assign done_fault   = fault_q;
  assign done_level   = level_q;
  assign done_paddr   = {base_q, va_q[OFF_W-1:0]};

  // R4: request held until accepted
  assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid);
  // R4: accepted read is never followed at once by another
  assert_single_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);
  // R5: a fault report follows a non-present response
  assert_fault_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> $past(mem_rsp_valid) && !$past(rsp_present));
  // R6: fill is followed by a clean completion
  assert_fill_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> done_valid && !done_fault && done_level == LAST_LVL);
  // R7: accepting a request makes the block busy
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R6: at most one of read, fill, completion in any cycle
  assert_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_valid, fill_valid, done_valid}));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PFN_W-1:0]  root_pfn,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              fill_valid,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PFN_W-1:0]  fill_pfn,
  output logic              done_valid,
  output logic              done_fault,
  output logic [LVL_W-1:0]  done_level,
  output logic [VA_W-1:0]   done_vaddr,
  output logic [PA_W-1:0]   done_paddr
);
  logic             rsp_present;
  logic [PFN_W-1:0] rsp_pfn;
  logic [LVL_W-1:0] cur_level;
  logic [PFN_W-1:0] cur_pfn;
  logic [VA_W-1:0]  cur_vaddr;

  ptw_entry_dec #(.ENT_W(ENT_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_dec (
    .entry    (mem_rsp_data),
    .present  (rsp_present),
    .next_pfn (rsp_pfn)
  );

  ptw_index_sel #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS),
    .PFN_W(PFN_W), .ENT_LG(ENT_LG)
  ) u_idx (
    .vaddr      (cur_vaddr),
    .level      (cur_level),
    .table_pfn  (cur_pfn),
    .entry_addr (mem_rd_addr)
  );

  ptw_ctrl #(.VA_W(VA_W), .OFF_W(OFF_W), .LEVELS(LEVELS), .PFN_W(PFN_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .root_pfn      (root_pfn),
    .req_ready     (req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_present   (rsp_present),
    .rsp_pfn       (rsp_pfn),
    .cur_level     (cur_level),
    .cur_pfn       (cur_pfn),
    .cur_vaddr     (cur_vaddr),
    .fill_valid    (fill_valid),
    .fill_vpn      (fill_vpn),
    .fill_pfn      (fill_pfn),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_level    (done_level),
    .done_paddr    (done_paddr)
  );

  assign done_vaddr = cur_vaddr;

  // R4: address stays put while a read waits for acceptance
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> $stable(mem_rd_addr));
endmodule

// File: tb/sim_page_walker.sv
`timescale 1ns/1ps
module sim_page_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [47:0] req_vaddr;
  logic [39:0] root_pfn;
  logic        mem_rd_valid, mem_rd_ready;
  logic [51:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        fill_valid;
  logic [35:0] fill_vpn;
  logic [39:0] fill_pfn;
  logic        done_valid, done_fault;
  logic [1:0]  done_level;
  logic [47:0] done_vaddr;
  logic [51:0] done_paddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  page_walker u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entry content derived from its own address; junk in bits 63:52 and 11:1 (R8)
  function automatic logic [63:0] mk_entry(input logic [51:0] a, input bit present);
    logic [39:0] n;
    n = a[42:3] ^ 40'h5A5A0F0F3C;
    return {12'hFA5, n, 11'h2AA, present};
  endfunction

  task automatic run_walk(input logic [47:0] va, input logic [39:0] root,
                          input int flt, input int rdly, input int sdly, input bit poke);
    logic [39:0] base;
    logic [51:0] ea;
    logic [63:0] ent;
    logic [8:0]  idx;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; root_pfn = root;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = ~va; root_pfn = ~root;
    chk(req_ready == 1'b0, "R7 busy after accept", 64'(req_ready), 64'd0);
    base = root;
    for (int lv = 0; lv < 4; lv++) begin
      idx = va[47 - 9*lv -: 9];
      ea  = {base, idx, 3'b000};
      chk(mem_rd_valid == 1'b1, "R4 read issued", 64'(mem_rd_valid), 64'd1);
      chk(mem_rd_addr == ea, "R2 R3 entry address", 64'(mem_rd_addr), 64'(ea));
      for (int d = 0; d < rdly; d++) begin
        @(negedge clk);
        chk(mem_rd_valid && mem_rd_addr == ea, "R4 hold until ready", 64'(mem_rd_addr), 64'(ea));
      end
      mem_rd_ready = 1'b1;
      @(negedge clk);
      mem_rd_ready = 1'b0;
      chk(mem_rd_valid == 1'b0, "R4 one outstanding", 64'(mem_rd_valid), 64'd0);
      if (poke) begin
        req_valid = 1'b1; req_vaddr = ~va;
      end
      for (int d = 0; d < sdly; d++) begin
        @(negedge clk);
        chk(!mem_rd_valid && !req_ready, "R4 R7 wait for response",
            64'({mem_rd_valid, req_ready}), 64'd0);
      end
      ent = mk_entry(ea, lv != flt);
      mem_rsp_valid = 1'b1; mem_rsp_data = ent;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0; req_valid = 1'b0;
      if (lv == flt) begin
        chk(done_valid && done_fault, "R5 fault reported", 64'({done_valid, done_fault}), 64'd3);
        chk(done_level == 2'(lv), "R5 fault level", 64'(done_level), 64'(lv));
        chk(done_vaddr == va, "R5 fault vaddr", 64'(done_vaddr), 64'(va));
        chk(!fill_valid && !mem_rd_valid, "R5 no fill no read", 64'({fill_valid, mem_rd_valid}), 64'd0);
        @(negedge clk);
        chk(req_ready && !done_valid && !mem_rd_valid, "R7 idle after fault",
            64'({req_ready, done_valid, mem_rd_valid}), 64'd4);
        return;
      end
      base = ent[51:12];
    end
    chk(fill_valid && !done_valid, "R6 fill first", 64'({fill_valid, done_valid}), 64'd2);
    chk(fill_vpn == va[47:12], "R6 fill vpn", 64'(fill_vpn), 64'(va[47:12]));
    chk(fill_pfn == base, "R6 R8 fill pfn", 64'(fill_pfn), 64'(base));
    @(negedge clk);
    chk(done_valid && !done_fault && !fill_valid, "R6 done after fill",
        64'({done_valid, done_fault, fill_valid}), 64'd4);
    chk(done_level == 2'd3, "R6 done level", 64'(done_level), 64'd3);
    chk(done_paddr == {base, va[11:0]}, "R6 paddr", 64'(done_paddr), 64'({base, va[11:0]}));
    @(negedge clk);
    chk(req_ready && !done_valid && !mem_rd_valid, "R7 no extra walk",
        64'({req_ready, done_valid, mem_rd_valid}), 64'd4);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_vaddr = '0; root_pfn = '0;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_rd_valid && !fill_valid && !done_valid, "R1 reset state",
        64'({req_ready, mem_rd_valid, fill_valid, done_valid}), 64'd8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_rd_valid && !fill_valid && !done_valid, "R1 idle after reset",
        64'({req_ready, mem_rd_valid, fill_valid, done_valid}), 64'd8);
    for (int flt = 0; flt <= 4; flt++) begin
      for (int p = 0; p < 5; p++) begin
        logic [47:0] va;
        case (p)
          0: va = 48'h0;
          1: va = 48'hFFFF_FFFF_FFFF;
          2: va = 48'hA5C3_1E7F_9B24;
          3: va = 48'h5555_AAAA_5555;
          default: va = {9'd1, 9'd2, 9'd4, 9'd8, 12'h123};
        endcase
        run_walk(va, 40'h12_3456_789A ^ 40'(p * 7 + flt), flt, (flt + p) % 3, p % 3, p[0]);
      end
    end
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule